// File: doc/BRIEF.md
# Embedded-Clock DC-Balanced Link Framer

This block turns a three-lane parallel video feed plus three slow side signals into one serial stream with the clock folded in. The clock `clk` runs at the serial bit rate, 28 cycles per pixel clock, and the block keeps its own frame slot counter that counts 0 to 27. Each lane offers one bit every fourth slot, so each lane gives seven bits per frame. The side signals are sampled once per frame. Lane and side bits form a 24-bit payload.

When a frame has been collected, the payload is XORed with a free-running LFSR mask. Its bits are then permuted, and the word is inverted when that reduces the running disparity. Overhead bits are added for the start edge, the inversion flag, a link-control bit and the stop edge. The 28-bit result is shifted out MSB first during the next frame, and a strobe marks its first bit. The side inputs are meant for level signals that change at less than a fifth of the pixel rate. Only the level seen at slot 0 travels.

Top module: `link_framer`

## Requirements
- R1: Lane l is sampled only at slots 4k (k = 0..6). That sample becomes payload bit 7*l + 6 - k, so the first bit of lane 0 is payload bit 6. Lane values at all other slots have no effect.
- R2: `side_in` and `ctl_in` are sampled only at slot 0. Side input s becomes payload bit 21 + s. The control bit becomes frame bit 25. Their values at other slots have no effect.
- R3: The payload is XORed with a mask whose bit i is LFSR bit (i mod 15). The 15-bit LFSR starts at 15'h4A5B for the first frame after reset. It advances once per frame as next = {cur[13:0], cur[14] ^ cur[13]}.
- R4: After randomizing, coded bit i equals randomized bit (5*i mod 24).
- R5: The word disparity is 2*ones - 24, and the running disparity starts at 0. When both values are nonzero and share a sign, the coded word is inverted, the flag is 1 and the running disparity decreases by the word disparity. Otherwise the word passes unchanged, the flag is 0 and the running disparity increases by the word disparity.
- R6: The frame is 28 bits, sent MSB first:
  - bit 27 = 1
  - bit 26 = inversion flag
  - bit 25 = control bit
  - bits 24..1 = coded bits 23..0
  - bit 0 = 0
- R7: A frame collected during slots 0..27 is sent during the next 28 slots. Its bit 27 - s appears on `ser_out` at slot s. `frame_start` is high only at slot 0 of a transmitted frame.
- R8: After reset, and until the first frame has been collected, `ser_out` and `frame_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit-rate clock, 28 cycles per pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | 3 | One bit per data lane, sampled every fourth slot |
| side_in | input | 3 | Slow level inputs, sampled at slot 0 |
| ctl_in | input | 1 | Link-control bit, sampled at slot 0 |
| ser_out | output | 1 | Serial frame bit, MSB first |
| frame_start | output | 1 | High during the first bit of each frame |

## Verification
Three things happen on the same clock edge: the inversion decision, the running-disparity update and the LFSR step all happen at the slot-27 edge, which is also where the shift register reloads. The bench knows the mask that will apply to each frame. It therefore builds payloads whose randomized words have every popcount from 0 to 24, run upward and then downward. This drives the running disparity to both signs and to zero, with zero-disparity words in between. Each received frame is judged field by field against an arithmetic model, and the strobe position is judged in the same frame. Junk is driven on the inputs at all non-sampling slots throughout.

// File: rtl/link_framer_pkg.sv
package link_framer_pkg;
  localparam int LFSR_W = 15;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // x^15 + x^14 + 1, shifting toward the MSB
  function automatic lfsr_t lfsr_next(input lfsr_t cur);
    return {cur[LFSR_W-2:0], cur[LFSR_W-1] ^ cur[LFSR_W-2]};
  endfunction
endpackage

// File: rtl/lf_lane_capture.sv
module lf_lane_capture #(
  parameter int LANES     = 3,
  parameter int LANE_BITS = 7,
  parameter int SIDE_BITS = 3,
  parameter int STEP      = 4,
  parameter int SLOT_W    = 5,
  localparam int PAY_W    = LANES * LANE_BITS + SIDE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic [LANES-1:0]  lane_in,
  input  logic [SIDE_BITS-1:0] side_in,
  input  logic              ctl_in,
  output logic [PAY_W-1:0]  payload,
  output logic              ctl
);
  logic [PAY_W-1:0] cap_q;
  logic             ctl_q;
  logic             at_zero;

  assign at_zero = (slot == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k < LANE_BITS; k++) begin : g_bit
      localparam int POS = l * LANE_BITS + (LANE_BITS - 1 - k);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cap_q[POS] <= 1'b0;
        else if (slot == SLOT_W'(k * STEP))    cap_q[POS] <= lane_in[l];
      end
    end
  end

  for (genvar s = 0; s < SIDE_BITS; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_q[LANES*LANE_BITS + s] <= 1'b0;
      else if (at_zero) cap_q[LANES*LANE_BITS + s] <= side_in[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= 1'b0;
    else if (at_zero) ctl_q <= ctl_in;
  end

  assign payload = cap_q;
  assign ctl     = ctl_q;
endmodule

// File: rtl/lf_encoder.sv
module lf_encoder
  import link_framer_pkg::*;
#(
  parameter int    PAY_W  = 24,
  parameter int    STRIDE = 5,
  parameter lfsr_t SEED   = 15'h4A5B,
  localparam int   DISP_W = $clog2(PAY_W + 1) + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [PAY_W-1:0]         payload,
  output logic [PAY_W-1:0]         coded,
  output logic                     flip,
  output logic signed [DISP_W-1:0] rd,
  output logic signed [DISP_W-1:0] word_disp
);
  lfsr_t                    lfsr_q;
  logic [PAY_W-1:0]         mask, randomized, permuted;
  logic signed [DISP_W-1:0] rd_q, rd_d;

  function automatic logic signed [DISP_W-1:0] disparity_of(input logic [PAY_W-1:0] w);
    int n;
    n = 0;
    for (int i = 0; i < PAY_W; i++) n += int'(w[i]);
    return DISP_W'(2 * n - PAY_W);
  endfunction

  for (genvar i = 0; i < PAY_W; i++) begin : g_mask
    assign mask[i] = lfsr_q[i % LFSR_W];
  end

  assign randomized = payload ^ mask;

  for (genvar i = 0; i < PAY_W; i++) begin : g_perm
    assign permuted[i] = randomized[(i * STRIDE) % PAY_W];
  end

  assign word_disp = disparity_of(permuted);
  assign flip = (word_disp != '0) && (rd_q != '0) &&
                (word_disp[DISP_W-1] == rd_q[DISP_W-1]);
  assign coded = permuted ^ {PAY_W{flip}};
  assign rd_d  = flip ? (rd_q - word_disp) : (rd_q + word_disp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      rd_q   <= '0;
    end else if (load) begin
      lfsr_q <= lfsr_next(lfsr_q);
      rd_q   <= rd_d;
    end
  end

  assign rd = rd_q;
endmodule

// File: rtl/lf_shifter.sv
module lf_shifter #(
  parameter int FRAME_W = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  output logic               ser_out,
  output logic               frame_start,
  output logic               primed
);
  logic [FRAME_W-1:0] sh_q;
  logic               stb_q, primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      stb_q    <= 1'b0;
      primed_q <= 1'b0;
    end else if (load) begin
      sh_q     <= word;
      stb_q    <= 1'b1;
      primed_q <= 1'b1;
    end else begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      stb_q <= 1'b0;
    end
  end

  assign ser_out     = sh_q[FRAME_W-1];
  assign frame_start = stb_q;
  assign primed      = primed_q;
endmodule

// File: rtl/link_framer.sv
module link_framer
  import link_framer_pkg::*;
#(
  parameter int    LANES     = 3,
  parameter int    LANE_BITS = 7,
  parameter int    SIDE_BITS = 3,
  parameter int    STRIDE    = 5,
  parameter lfsr_t SEED      = 15'h4A5B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES-1:0]     lane_in,
  input  logic [SIDE_BITS-1:0] side_in,
  input  logic                 ctl_in,
  output logic                 ser_out,
  output logic                 frame_start
);
  localparam int PAY_W   = LANES * LANE_BITS + SIDE_BITS;
  localparam int FRAME_W = PAY_W + 4;
  localparam int STEP    = FRAME_W / LANE_BITS;
  localparam int SLOT_W  = $clog2(FRAME_W);
  localparam int DISP_W  = $clog2(PAY_W + 1) + 3;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_W - 1);

  // named internal events, observed by the bound checker
  logic [SLOT_W-1:0]        slot_q;
  logic                     load_frame;
  logic                     flip_ev;
  logic                     primed;
  logic signed [DISP_W-1:0] rd_obs, word_disp;
  logic [PAY_W-1:0]         payload, coded;
  logic                     ctl_cap;
  logic [FRAME_W-1:0]       frame_word;

  assign load_frame = (slot_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          slot_q <= '0;
    else if (load_frame) slot_q <= '0;
    else                 slot_q <= slot_q + 1'b1;
  end

  lf_lane_capture #(
    .LANES(LANES), .LANE_BITS(LANE_BITS), .SIDE_BITS(SIDE_BITS),
    .STEP(STEP), .SLOT_W(SLOT_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .slot(slot_q), .lane_in(lane_in),
    .side_in(side_in), .ctl_in(ctl_in), .payload(payload), .ctl(ctl_cap)
  );

  lf_encoder #(.PAY_W(PAY_W), .STRIDE(STRIDE), .SEED(SEED)) u_enc (
    .clk(clk), .rst_n(rst_n), .load(load_frame), .payload(payload),
    .coded(coded), .flip(flip_ev), .rd(rd_obs), .word_disp(word_disp)
  );

  assign frame_word = {1'b1, flip_ev, ctl_cap, coded, 1'b0};

  lf_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_frame), .word(frame_word),
    .ser_out(ser_out), .frame_start(frame_start), .primed(primed)
  );
endmodule

// File: rtl/link_framer_chk.sv
module link_framer_chk #(
  parameter int SLOT_W = 5,
  parameter int DISP_W = 8,
  parameter int PAY_W  = 24,
  parameter int LAST   = 27
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SLOT_W-1:0]        slot,
  input logic                     load_frame,
  input logic                     primed,
  input logic signed [DISP_W-1:0] rd,
  input logic                     ser_out,
  input logic                     frame_start
);
  p_slot_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_W'(LAST));

  p_strobe_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_frame |=> frame_start);

  p_strobe_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(load_frame));

  p_first_bit_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ser_out);

  p_last_bit_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_frame && primed) |-> !ser_out);

  p_rd_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd >= -DISP_W'(PAY_W)) && (rd <= DISP_W'(PAY_W)));

  p_rd_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd[0]);

  p_rd_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_frame |=> $stable(rd));

  p_quiet_until_primed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (!ser_out && !frame_start));
endmodule

bind link_framer link_framer_chk #(
  .SLOT_W(SLOT_W), .DISP_W(DISP_W), .PAY_W(PAY_W), .LAST(FRAME_W - 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot_q), .load_frame(load_frame),
  .primed(primed), .rd(rd_obs), .ser_out(ser_out), .frame_start(frame_start)
);

// File: tb/link_framer_test.sv
`timescale 1ns/1ps
module link_framer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] lane_in = '0;
  logic [2:0] side_in = '0;
  logic       ctl_in = 1'b0;
  logic       ser_out, frame_start;

  int n_cmp = 0;
  int n_bad = 0;

  logic [14:0] b_lfsr = 15'h4A5B;
  int          b_rd = 0;
  logic [27:0] exp_word = '0;
  bit          exp_valid = 1'b0;
  string       exp_tag = "R1";

  always #2 clk = ~clk;

  link_framer uut (
    .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .side_in(side_in),
    .ctl_in(ctl_in), .ser_out(ser_out), .frame_start(frame_start)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mask_now();
    logic [23:0] m;
    for (int i = 0; i < 24; i++) m[i] = b_lfsr[i % 15];
    return m;
  endfunction

  // bench model of one frame, updates model state
  function automatic logic [27:0] model_frame(input logic [23:0] pay, input logic ctl);
    logic [23:0] r, c;
    int ones, d;
    logic inv, fb;
    r = pay ^ mask_now();
    for (int i = 0; i < 24; i++) c[i] = r[(i * 5) % 24];
    ones = 0;
    for (int i = 0; i < 24; i++) if (c[i]) ones++;
    d = ones + ones - 24;
    inv = (d != 0) && (b_rd != 0) && ((d > 0) == (b_rd > 0));
    if (inv) begin c = ~c; b_rd = b_rd - d; end
    else     b_rd = b_rd + d;
    fb = b_lfsr[14] ^ b_lfsr[13];
    b_lfsr = b_lfsr << 1;
    b_lfsr[0] = fb;
    return {1'b1, inv, ctl, c, 1'b0};
  endfunction

  // one 28-slot frame: drive inputs, receive the previous frame
  task automatic run_frame(input logic [23:0] pay, input logic ctl, input string tag);
    logic [27:0] rx, stb;
    rx = '0; stb = '0;
    for (int s = 0; s < 28; s++) begin
      rx[27 - s]  = ser_out;
      stb[27 - s] = frame_start;
      for (int l = 0; l < 3; l++)
        lane_in[l] = (s % 4 == 0) ? pay[7 * l + 6 - s / 4] : 1'($urandom);
      side_in = (s == 0) ? pay[23:21] : 3'($urandom);
      ctl_in  = (s == 0) ? ctl : 1'($urandom);
      @(negedge clk);
    end
    if (exp_valid) begin
      check("R6 start/stop bits", {62'b0, rx[27], rx[0]}, 64'h2);
      check("R5 inversion flag", 64'(rx[26]), 64'(exp_word[26]));
      check("R2 control bit", 64'(rx[25]), 64'(exp_word[25]));
      check({exp_tag, " coded payload"}, 64'(rx[24:1]), 64'(exp_word[24:1]));
      check("R7 strobe position", 64'(stb), 64'h800_0000);
    end else begin
      check("R8 idle output", 64'(rx), 64'h0);
      check("R8 idle strobe", 64'(stb), 64'h0);
    end
    exp_word  = model_frame(pay, ctl);
    exp_valid = 1'b1;
    exp_tag   = tag;
  endtask

  // choose the randomized word directly, payload follows from the mask
  task automatic crafted(input logic [23:0] w, input logic ctl, input string tag);
    run_frame(w ^ mask_now(), ctl, tag);
  endtask

  initial begin
    #(4ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    check("R8 reset ser_out", 64'(ser_out), 64'h0);
    check("R8 reset strobe", 64'(frame_start), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 lane mapping and R2 side mapping: walking one through raw payload
    for (int b = 0; b < 24; b++)
      run_frame(24'h1 << b, b[0], (b >= 21) ? "R2" : "R1");

    // R5 popcount sweep up and down, both disparity signs and zero
    for (int k = 0; k <= 24; k++)
      crafted(24'((64'h1 << k) - 1), k[1], "R5");
    for (int k = 24; k >= 0; k--)
      crafted(24'((64'h1 << k) - 1) << (24 - k), k[0], "R5");
    crafted(24'h0, 1'b0, "R5");
    crafted(24'hFFF000, 1'b1, "R5");
    crafted(24'hFFFFFF, 1'b0, "R5");

    // R3 randomizer: all-zero and all-one raw payloads expose the mask
    for (int n = 0; n < 8; n++)
      run_frame(n[0] ? 24'hFFFFFF : 24'h0, 1'b0, "R3");

    // R4 permutation with random payloads
    for (int n = 0; n < 40; n++)
      run_frame(24'($urandom), 1'($urandom), "R4");

    // flush the last frame
    run_frame(24'h0, 1'b0, "R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule